// File: doc/BRIEF.md
# Full-Cycle SPI Host Shifter

This block is the serial engine of a host that exchanges bytes with a serial flash device at high SCK rates. It drives SCK, MOSI and an active-low chip select, and reads MISO. Every bit gets a whole SCK period on the wire in each direction. The host launches MOSI on a rising edge, and the device takes it on the next rising edge. The device launches MISO on a falling edge, and the host latches it on the next falling edge, not on the rising edge between them. Because host sampling lags by a full period, each byte has a ninth SCK period. That extra period carries the last MISO bit into the host before the byte is reported.

A user logic block pulses `start` with a byte on `txByte` and chooses with `holdCs` whether chip select stays low after that byte. The engine shifts the byte out most significant bit first. It gathers the device's byte, presents it on `rxByte` with a one-cycle `rxValid` pulse, and keeps `busy` high while the byte is in flight. SCK is derived from the system clock. Each SCK half period lasts `DIV_HALF` system clocks, and this count is fixed by a parameter, so it cannot change during a transfer. A command followed by a reply is a run of held bytes. The run ends with a byte sent with `holdCs` low.

Top module: `spi_fc_host`

## Requirements
- R1: After reset, and whenever chip select is high, `csN`=1, `sck`=0 and `busy`=0.
- R2: SCK stays low while `csN` is high and idles low between held bytes.
- R3: While chip select is low, MOSI changes only in the cycle where SCK rises. The first bit appears together with the first rising edge.
- R4: Each byte is sent most significant bit first. The device, sampling MOSI on the rising edge after each launch, receives exactly `txByte`.
- R5: Each byte takes nine SCK periods. The host samples MISO on falling edges 2 through 9, first sample as bit 7, so `rxByte` equals the byte the device drove on falling edges 1 through 8.
- R6: `rxValid` is a single-cycle pulse. It occurs with chip select low and SCK low, directly after the ninth falling edge.
- R7: At the start of a frame, `csN` falls exactly `DIV_HALF` system clocks before the first SCK rising edge, and never on the same cycle as it.
- R8: When a byte ends with `holdCs`=0, `csN` rises exactly 2*`DIV_HALF` system clocks (one SCK period) after the final falling edge.
- R9: When a byte ends with `holdCs`=1, `csN` stays low with `busy`=0, and the next `start` begins the following byte within the same frame.
- R10: Every SCK high phase lasts exactly `DIV_HALF` system clocks.
- R11: `busy` rises in the cycle after an accepted `start` and stays high until the byte completes (or until chip select is released).
- R12: A `start` pulse while `busy` is high is ignored. The byte in flight and the number of bytes sent are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send `txByte` |
| txByte | input | BYTE_W | Byte to transmit, captured on an accepted `start` |
| holdCs | input | 1 | 1 keeps chip select low after this byte |
| rxByte | output | BYTE_W | Last byte received from the device |
| rxValid | output | 1 | One-cycle pulse when `rxByte` is updated |
| busy | output | 1 | A byte is in flight or chip select is being released |
| sck | output | 1 | Serial clock to the device |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The checks assume that the device changes MISO only on SCK falling edges. They also assume that `DIV_HALF` is at least 2, so chip select and the edges never coincide. The bench device model drives MISO from falling edges. It captures MOSI using the value seen at the preceding falling edge, so its sampling of MOSI does not depend on the simulator's event order. `start` is raised only on the falling system-clock edge. Besides the regular requests, it is also pulsed deliberately while busy, so that the ignore rule gets exercised.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_SHIFT = 3'd2,
    ST_HOLD  = 3'd3,
    ST_TRAIL = 3'd4
  } fcState_t;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic load;      // capture transmit byte
    logic csLow;     // assert chip select
    logic csHigh;    // release chip select, park MOSI
    logic rise;      // SCK low -> high
    logic fall;      // SCK high -> low
    logic shiftOut;  // launch next MOSI bit
    logic sampleIn;  // latch one MISO bit
    logic done;      // last MISO bit: publish received byte
  } fcStrobe_t;

endpackage

// File: rtl/spi_fc_ctrl.sv
module spi_fc_ctrl
  import spi_fc_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int BYTE_W   = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      holdCs,
  output fcStrobe_t stb,
  output logic      busy
);

  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W);

  fcState_t         state, nextState;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sckHigh;
  logic             holdLat;
  logic             trailCnt;
  logic             tick;
  logic             accept;

  assign tick   = (divCnt == DIV_LAST);
  assign accept = start && ((state == ST_IDLE) || (state == ST_HOLD));
  assign busy   = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_TRAIL);

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.load  = 1'b1;
          stb.csLow = 1'b1;
          nextState = ST_SETUP;
        end
      end
      ST_HOLD: begin
        if (start) begin
          stb.load  = 1'b1;
          nextState = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          stb.rise     = 1'b1;
          stb.shiftOut = 1'b1;
          nextState    = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sckHigh) begin
            stb.fall     = 1'b1;
            stb.sampleIn = (bitCnt != '0);
            if (bitCnt == BIT_LAST) begin
              stb.done  = 1'b1;
              nextState = holdLat ? ST_HOLD : ST_TRAIL;
            end
          end else begin
            stb.rise     = 1'b1;
            stb.shiftOut = (bitCnt < BIT_LAST);
          end
        end
      end
      ST_TRAIL: begin
        if (tick && trailCnt) begin
          stb.csHigh = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      sckHigh  <= 1'b0;
      holdLat  <= 1'b0;
      trailCnt <= 1'b0;
    end else begin
      state <= nextState;

      if ((state == ST_IDLE) || (state == ST_HOLD) || tick) begin
        divCnt <= '0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end

      if (accept) begin
        holdLat <= holdCs;
        bitCnt  <= '0;
      end else if (stb.fall && (bitCnt != BIT_LAST)) begin
        bitCnt <= bitCnt + 1'b1;
      end

      if (stb.rise) begin
        sckHigh <= 1'b1;
      end else if (stb.fall) begin
        sckHigh <= 1'b0;
      end

      if (stb.done) begin
        trailCnt <= 1'b0;
      end else if ((state == ST_TRAIL) && tick) begin
        trailCnt <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_fc_datapath.sv
module spi_fc_datapath
  import spi_fc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcStrobe_t         stb,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              miso,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              sck,
  output logic              csN,
  output logic              mosi
);

  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] rxNext;

  assign rxNext = {rxShift[BYTE_W-2:0], miso};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
      sck     <= 1'b0;
      csN     <= 1'b1;
      mosi    <= 1'b0;
    end else begin
      rxValid <= stb.done;

      if (stb.load) begin
        txShift <= txByte;
      end else if (stb.shiftOut) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end

      if (stb.shiftOut) begin
        mosi <= txShift[BYTE_W-1];
      end else if (stb.csHigh) begin
        mosi <= 1'b0;
      end

      if (stb.rise) begin
        sck <= 1'b1;
      end else if (stb.fall) begin
        sck <= 1'b0;
      end

      if (stb.csLow) begin
        csN <= 1'b0;
      end else if (stb.csHigh) begin
        csN <= 1'b1;
      end

      if (stb.sampleIn) begin
        rxShift <= rxNext;
      end

      if (stb.done) begin
        rxByte <= rxNext;
      end
    end
  end

endmodule

// File: rtl/spi_fc_host.sv
module spi_fc_host
  import spi_fc_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              holdCs,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              busy,
  output logic              sck,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);

  fcStrobe_t stb;

  spi_fc_ctrl #(
    .DIV_HALF(DIV_HALF),
    .BYTE_W  (BYTE_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .holdCs(holdCs),
    .stb   (stb),
    .busy  (busy)
  );

  spi_fc_datapath #(
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .txByte (txByte),
    .miso   (miso),
    .rxByte (rxByte),
    .rxValid(rxValid),
    .sck    (sck),
    .csN    (csN),
    .mosi   (mosi)
  );

endmodule

// File: rtl/spi_fc_host_checks.sv
module spi_fc_host_checks #(
  parameter int DIV_HALF = 2
) (
  input logic clk,
  input logic rstN,
  input logic sck,
  input logic csN,
  input logic mosi,
  input logic rxValid,
  input logic busy
);

  localparam int CNT_MAX = 4 * DIV_HALF;
  localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;

  logic [CNT_W-1:0] hiCnt;
  logic [CNT_W-1:0] sinceFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt     <= '0;
      sinceFall <= '0;
    end else begin
      if (!sck) hiCnt <= '0;
      else if (hiCnt < CNT_W'(CNT_MAX)) hiCnt <= hiCnt + 1'b1;
      if (sck) sinceFall <= '0;
      else if (sinceFall < CNT_W'(CNT_MAX)) sinceFall <= sinceFall + 1'b1;
    end
  end

  // R1
  p_idle_not_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !busy);
  // R2
  p_sck_low_when_deselected_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);
  // R3
  p_mosi_moves_on_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && (mosi != $past(mosi))) |-> $rose(sck));
  // R6
  p_rxvalid_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  p_rxvalid_framed_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (!csN && !sck));
  // R7
  p_cs_before_first_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> (!csN && !$past(csN)));
  // R8
  p_cs_release_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (sinceFall >= CNT_W'(2 * DIV_HALF)));
  // R10
  p_high_phase_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sck) |-> (hiCnt == CNT_W'(DIV_HALF)));

endmodule

bind spi_fc_host spi_fc_host_checks #(.DIV_HALF(DIV_HALF)) u_checks (
  .clk    (clk),
  .rstN   (rstN),
  .sck    (sck),
  .csN    (csN),
  .mosi   (mosi),
  .rxValid(rxValid),
  .busy   (busy)
);

// File: tb/spi_fc_host_test.sv
`timescale 1ns/1ps
module spi_fc_host_test;

  localparam int DIV = 2;
  localparam logic [7:0] FIRST_REPLY = 8'hA5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] txByte = '0;
  logic       holdCs = 1'b0;
  logic [7:0] rxByte;
  logic       rxValid, busy, sck, csN, mosi;
  logic       miso = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit timedOut = 0;

  always #2.5 clk = ~clk;

  spi_fc_host #(.DIV_HALF(DIV), .BYTE_W(8)) uut (
    .clk(clk), .rstN(rstN), .start(start), .txByte(txByte), .holdCs(holdCs),
    .rxByte(rxByte), .rxValid(rxValid), .busy(busy),
    .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  // Loopback device: replies with the previous byte of the frame.
  int         riseCnt = 0;
  logic       mosiSeen = 1'b0;
  logic [7:0] devShift = '0;
  logic [7:0] nextReply = FIRST_REPLY;
  logic [7:0] devRx [0:255];
  int         devCnt = 0;

  always @(negedge csN) begin
    riseCnt = 0;
    nextReply = FIRST_REPLY;
  end

  always @(posedge sck) begin
    riseCnt = (riseCnt == 9) ? 1 : riseCnt + 1;
    if (riseCnt >= 2) devShift = {devShift[6:0], mosiSeen};
    if (riseCnt == 9) begin
      devRx[devCnt[7:0]] = devShift;
      devCnt++;
      nextReply = devShift;
    end
  end

  always @(negedge sck) begin
    mosiSeen = mosi;
    if (riseCnt >= 1 && riseCnt <= 8) miso <= nextReply[3'(8 - riseCnt)];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !timedOut) timedOut = 1;
  end

  function automatic logic [7:0] expectReply(bit first, logic [7:0] prev);
    return first ? FIRST_REPLY : prev;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] prevTx = '0;
  bit         frameFirst = 1;

  task automatic waitIdle();
    int n = 0;
    while (busy && !timedOut && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic sendByte(logic [7:0] tx, bit hold);
    int n;
    int devBefore;
    logic [7:0] exp;
    waitIdle();
    devBefore = devCnt;
    exp = expectReply(frameFirst, prevTx);
    @(negedge clk);
    start = 1; txByte = tx; holdCs = hold;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    if (frameFirst) begin
      n = 0;
      while (!sck && !timedOut && n < 100) begin @(negedge clk); n++; end
      check(n == DIV, "R7 cs-to-first-rise", n, DIV);
      check(csN == 1'b0, "R7 cs low at first rise", csN, 0);
    end
    n = 0;
    while (!rxValid && !timedOut && n < 1000) begin
      @(negedge clk); n++;
      check(busy == 1'b1 || rxValid, "R11 busy during byte", busy, 1);
    end
    check(rxByte == exp, "R5 received byte", rxByte, exp);
    check(devCnt == devBefore + 1, "R4 device byte count", devCnt, devBefore + 1);
    check(devRx[devBefore[7:0]] == tx, "R4 device got tx MSB first", devRx[devBefore[7:0]], tx);
    @(negedge clk);
    check(rxValid == 1'b0, "R6 rxValid single pulse", rxValid, 0);
    if (hold) begin
      repeat (3) @(negedge clk);
      check(csN == 1'b0 && busy == 1'b0, "R9 held frame cs low, idle", {csN, busy}, 0);
      check(sck == 1'b0, "R2 sck idles low in hold", sck, 0);
      frameFirst = 0;
    end else begin
      n = 1;
      while (!csN && !timedOut && n < 1000) begin @(negedge clk); n++; end
      check(n == 2 * DIV, "R8 cs release gap", n, 2 * DIV);
      check(busy == 1'b0 && sck == 1'b0, "R1 idle after release", {busy, sck}, 0);
      frameFirst = 1;
    end
    prevTx = tx;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0 && busy == 1'b0 && rxValid == 1'b0,
          "R1 reset state", {csN, sck, busy, rxValid}, 4'b1000);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0, "R2 idle lines", {csN, sck}, 2'b10);

    // Directed single-byte frames: edge patterns
    sendByte(8'h00, 0);
    sendByte(8'hFF, 0);
    sendByte(8'h80, 0);
    sendByte(8'h01, 0);

    // Held frame, command plus replies
    sendByte(8'h3C, 1);
    sendByte(8'hC3, 1);
    sendByte(8'h5A, 1);
    sendByte(8'h96, 0);

    // R10: measure one high phase in a fresh frame
    begin
      int hi = 0;
      int n = 0;
      @(negedge clk);
      start = 1; txByte = 8'h71; holdCs = 0;
      @(negedge clk);
      start = 0;
      while (!sck && n < 100) begin @(negedge clk); n++; end
      while (sck && hi < 100) begin @(negedge clk); hi++; end
      check(hi == DIV, "R10 high phase length", hi, DIV);
      // R12: start while busy is ignored
      start = 1; txByte = 8'hEE; holdCs = 1;
      @(negedge clk);
      start = 0;
      n = 0;
      while (!rxValid && n < 1000) begin @(negedge clk); n++; end
      check(devRx[(devCnt - 1) & 255] == 8'h71, "R12 in-flight byte unchanged",
            devRx[(devCnt - 1) & 255], 8'h71);
      n = 1;
      while (!csN && n < 1000) begin @(negedge clk); n++; end
      check(csN == 1'b1, "R12 hold from ignored start not applied", csN, 1);
      repeat (4 * DIV) @(negedge clk);
      check(busy == 1'b0 && csN == 1'b1, "R12 no extra byte started", {busy, csN}, 2'b01);
      frameFirst = 1;
    end

    // Random frames
    for (int f = 0; f < 20; f++) begin
      int len = 1 + ($urandom % 5);
      for (int b = 0; b < len; b++) begin
        sendByte(8'($urandom), (b != len - 1));
      end
    end

    if (timedOut) check(0, "watchdog", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (timedOut);
    repeat (10) @(negedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule